// File: doc/BRIEF.md
# Four-Bit-Selected 32-Bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for a simple integer datapath. It takes two operand words and a 4-bit operation select. It returns a result word and three flags: one for an all-zero result, one for signed overflow, and one for the carry out of the top bit. The supported operations are three bitwise functions (AND, OR, NOR), addition, subtraction, and a signed set-on-less-than that yields 1 or 0.

A single shared adder handles addition, subtraction and the comparison. For subtraction and comparison the second operand is inverted and a carry-in of 1 is applied. The comparison does not use the raw sign of the difference. It takes the difference sign XORed with the overflow condition, so the answer stays correct when the subtraction wraps. Any select value outside the six defined codes gives a zero result. The block holds no state: every output follows its inputs in the same cycle.

Top module: `alu32_core`

## Requirements
- R1: Select 4'b0000 makes the result the bitwise AND of a and b.
- R2: Select 4'b0001 makes the result the bitwise OR of a and b.
- R3: Select 4'b0010 makes the result a + b modulo 2^32, and carry_out is the bit-32 carry of that unsigned sum.
- R4: Select 4'b0110 makes the result a - b modulo 2^32, and carry_out is the bit-32 carry of a + ~b + 1, which is 1 exactly when a >= b as unsigned values.
- R5: Under add or subtract, overflow is 1 exactly when the true signed result does not fit in 32 bits.
- R6: Under every select other than add and subtract, overflow and carry_out are both 0.
- R7: Select 4'b0111 gives result 32'd1 when a < b as signed two's-complement values, and 32'd0 otherwise. Bits 31..1 are always 0.
- R8: Select 4'b1100 makes the result the bitwise NOR of a and b.
- R9: zero is 1 exactly when all 32 result bits are 0, for every select.
- R10: Any select value not listed in R1 to R8 gives result 0, with zero at 1 and both overflow and carry_out at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| op_sel | input | 4 | Operation select code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of bit 31 for add or subtract |

## Verification
The embedded assertions are checked whenever the inputs change. They cover these behaviours:
- The comparison result matches a signed compare and keeps its upper 31 bits at zero.
- The flags stay low outside add and subtract.
- An add gives a 33-bit sum that matches the operands.
- A subtraction of equal operands gives zero with carry set.
- An undefined select gives a zero result.

Only the bench's scenarios exercise the full truth of each operation against independently written models. Those scenarios are:
- the bitwise functions;
- overflow at the signed limits;
- carry on unsigned wraparound;
- comparisons across the sign boundary, where the raw difference sign would give the wrong answer;
- the sweep over all ten unused select codes.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_AND = 4'b0000,
    SEL_OR  = 4'b0001,
    SEL_ADD = 4'b0010,
    SEL_SUB = 4'b0110,
    SEL_SLT = 4'b0111,
    SEL_NOR = 4'b1100
  } alu_sel_e;

endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             do_sub,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             sgn_ovf
);
  localparam int unsigned MSB = WIDTH - 1;

  // Unsigned sum with an explicit carry-in, one bit wider than the operands.
  function automatic logic [WIDTH:0] wide_add(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             cin
  );
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  // Signed overflow: same-sign inputs whose sum sign flipped.
  function automatic logic ovf_rule(
    input logic xs,
    input logic ys,
    input logic ss
  );
    return (xs == ys) && (ss != xs);
  endfunction

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  assign b_eff   = do_sub ? ~opb : opb;
  assign full    = wide_add(opa, b_eff, do_sub);
  assign sum     = full[MSB:0];
  assign cout    = full[WIDTH];
  assign sgn_ovf = ovf_rule(opa[MSB], b_eff[MSB], full[MSB]);
endmodule

// File: rtl/alu32_bitwise.sv
module alu32_bitwise #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] and_w,
  output logic [WIDTH-1:0] or_w,
  output logic [WIDTH-1:0] nor_w
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign and_w[i] = opa[i] & opb[i];
    assign or_w[i]  = opa[i] | opb[i];
    assign nor_w[i] = ~(opa[i] | opb[i]);
  end
endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SEL_W-1:0] op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);
  localparam int unsigned MSB = WIDTH - 1;

  // Decoded selects, brought out as named wires.
  logic is_and, is_or, is_add, is_sub, is_slt, is_nor, is_arith, is_known;

  assign is_and   = (op_sel == SEL_AND);
  assign is_or    = (op_sel == SEL_OR);
  assign is_add   = (op_sel == SEL_ADD);
  assign is_sub   = (op_sel == SEL_SUB);
  assign is_slt   = (op_sel == SEL_SLT);
  assign is_nor   = (op_sel == SEL_NOR);
  assign is_arith = is_add | is_sub;
  assign is_known = is_and | is_or | is_arith | is_slt | is_nor;

  logic [WIDTH-1:0] sum_w, and_w, or_w, nor_w;
  logic             cout_raw, ovf_raw, less_w;

  alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
    .opa     (a),
    .opb     (b),
    .do_sub  (is_sub | is_slt),
    .sum     (sum_w),
    .cout    (cout_raw),
    .sgn_ovf (ovf_raw)
  );

  alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .opa   (a),
    .opb   (b),
    .and_w (and_w),
    .or_w  (or_w),
    .nor_w (nor_w)
  );

  // Signed less-than: difference sign corrected by overflow.
  assign less_w = sum_w[MSB] ^ ovf_raw;

  always_comb begin
    result = '0;
    if (is_and)   result = and_w;
    if (is_or)    result = or_w;
    if (is_arith) result = sum_w;
    if (is_slt)   result = {{(WIDTH-1){1'b0}}, less_w};
    if (is_nor)   result = nor_w;
  end

  assign zero      = ~|result;
  assign overflow  = ovf_raw  & is_arith;
  assign carry_out = cout_raw & is_arith;

  // Checks held next to the result and flag logic.
  always_comb begin
    if (is_slt) begin
      assert_slt_signed_R7: assert (result[MSB:1] == '0 &&
                                    result[0] == ($signed(a) < $signed(b)))
        else $error("slt mismatch");
    end
    if (!is_arith) begin
      assert_flags_idle_R6: assert (!overflow && !carry_out)
        else $error("flags set outside add/sub");
    end
    if (is_add) begin
      assert_add_carry_R3: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b}))
        else $error("add sum/carry mismatch");
    end
    if (is_sub && a == b) begin
      assert_sub_equal_R4: assert (zero && carry_out && !overflow)
        else $error("equal subtract flags wrong");
    end
    if (!is_known) begin
      assert_unlisted_R10: assert (result == '0 && zero)
        else $error("unlisted select nonzero");
    end
  end
endmodule

// File: tb/alu32_core_tb.sv
module alu32_core_tb;
  logic        clk = 1'b0;
  logic [31:0] a, b;
  logic [3:0]  op_sel;
  logic [31:0] result;
  logic        zero, overflow, carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  alu32_core u_dut (
    .a(a), .b(b), .op_sel(op_sel),
    .result(result), .zero(zero), .overflow(overflow), .carry_out(carry_out)
  );

  // Bench models, written independently of the RTL structure.
  function automatic logic [31:0] m_res(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y);
    case (s)
      4'b0000: return x & y;
      4'b0001: return x | y;
      4'b0010: return x + y;
      4'b0110: return x - y;
      4'b0111: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'b1100: return ~(x | y);
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_ovf(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint r;
    if (s == 4'b0010)      r = sx + sy;
    else if (s == 4'b0110) r = sx - sy;
    else return 1'b0;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  function automatic logic m_cout(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y);
    if (s == 4'b0010) return (longint'(x) + longint'(y)) > 64'd4294967295;
    if (s == 4'b0110) return x >= y;
    return 1'b0;
  endfunction

  function automatic string req_of(input logic [3:0] s);
    case (s)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R7";
      4'b1100: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive just after a rising edge, sample on the falling edge.
  task automatic run(input logic [3:0] s, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] er;
    @(posedge clk);
    #1;
    op_sel = s; a = x; b = y;
    @(negedge clk);
    er = m_res(s, x, y);
    chk(req_of(s), "result", result, er);
    chk("R9", "zero", {31'd0, zero}, {31'd0, er == 32'd0});
    if (s == 4'b0010 || s == 4'b0110) begin
      chk("R5", "overflow", {31'd0, overflow}, {31'd0, m_ovf(s, x, y)});
      chk(s == 4'b0010 ? "R3" : "R4", "carry", {31'd0, carry_out}, {31'd0, m_cout(s, x, y)});
    end else begin
      chk("R6", "overflow", {31'd0, overflow}, 32'd0);
      chk("R6", "carry", {31'd0, carry_out}, 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [3:0] ops [6];
    int unsigned seed;
    ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    seed = 32'h1234_5678;
    void'($urandom(seed));
    a = '0; b = '0; op_sel = 4'b0000;

    // Idle state: AND of zeros gives zero result.
    @(negedge clk);
    chk("R9", "idle zero", {31'd0, zero}, 32'd1);
    chk("R1", "idle result", result, 32'd0);

    // Directed corners.
    run(4'b0010, 32'h7fffffff, 32'd1);          // R5 positive overflow
    run(4'b0010, 32'h80000000, 32'h80000000);   // R5 negative overflow, R3 carry
    run(4'b0010, 32'hffffffff, 32'd1);          // R3 carry, R9 zero
    run(4'b0110, 32'h80000000, 32'd1);          // R5 subtract overflow
    run(4'b0110, 32'd5, 32'd5);                 // R4 equal, carry 1
    run(4'b0110, 32'd3, 32'd7);                 // R4 borrow, carry 0
    run(4'b0111, 32'h80000000, 32'h7fffffff);   // R7 across sign boundary
    run(4'b0111, 32'h7fffffff, 32'h80000000);   // R7 false case
    run(4'b0111, 32'hffffffff, 32'd0);          // R7 -1 < 0
    run(4'b0111, 32'd4, 32'd4);                 // R7 equal
    run(4'b1100, 32'd0, 32'd0);                 // R8 all ones
    run(4'b1100, 32'hffffffff, 32'd0);          // R8 zero result
    run(4'b0000, 32'hf0f0f0f0, 32'h0ff00ff0);   // R1
    run(4'b0001, 32'hf0000000, 32'h0000000f);   // R2

    // R10: sweep every unlisted select code.
    for (int c = 0; c < 16; c++) begin
      if (!(c inside {0, 1, 2, 6, 7, 12}))
        run(c[3:0], 32'hdeadbeef, 32'h12345678);
    end

    // Constrained random: each defined op, with biased operand sign bits.
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] x, y;
        x = $urandom();
        y = (n % 4 == 0) ? x : $urandom();
        if (n % 5 == 1) x[31] = ~y[31];
        run(ops[k], x, y);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule